// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This block keeps the status byte of a serial nonvolatile memory and decides, cycle by cycle, whether a memory write and a status write may go ahead. The command decoder upstream gives it one-cycle strobes for set-write-enable, clear-write-enable and write-status (with its data byte). It also gives the address of the byte being written and a strobe that marks the falling edge of chip select. On that strobe the hardware write-protect pin is captured. The memory datapath reads `status_byte` for status reads and gates each byte write with `mem_wr_ok`.

Three mechanisms act together. A software write-enable latch must be set before any write. A two-bit block-protect code fences off the top quarter, the top half or the whole array. A lock bit (`wp_en`, bit 7) makes the captured pin able to freeze the status register. With the fence at full array, the lock set and the pin low, no command sequence can enable a memory write until the pin goes high at a later chip-select fall. The write-enable latch is a two-state machine: state `WEL_CLEAR` moves to `WEL_SET` on the transition *arm* (set strobe), and `WEL_SET` moves to `WEL_CLEAR` on the transition *disarm* (clear strobe). Every other cycle holds the state. The fence code, the lock bit and the captured pin are plain registers. The fence code and the lock bit take their reset values from parameters, which model retained contents.

Top module: `srwp_status_top`

## Requirements
- R1: `status_byte` bit 6 always reads 1 and bits 5, 4 and 0 always read 0, whatever data a status write carries.
- R2: The write-enable latch (status bit 1) goes to 1 the cycle after `cmd_wren` and to 0 the cycle after `cmd_wrdi`. A status write has no effect on it, whatever value bit 1 of the data holds.
- R3: The fence code sits in status bits 3:2. Code 00 guards no address. Code 01 guards addresses 30000h–3FFFFh and code 10 guards 20000h–3FFFFh. Code 11 guards every address. `mem_wr_ok` is 0 for a guarded address.
- R4: `mem_wr_ok` is 1 exactly when the write-enable latch is 1 and `mem_addr` is not guarded. No other input affects it.
- R5: `sr_wr_ok` is 0 when the lock bit (status bit 7) is 1 and the captured pin is low. When the lock bit is 0 the pin level has no effect, and `sr_wr_ok` then equals the write-enable latch.
- R6: `wp_n_pin` is captured only in cycles where `cs_fall` is 1. A pin change between chip-select falls has no effect until the next one.
- R7: A status write needs the write-enable latch set and no lock. When allowed, it loads bits 7 and 3:2 from the data one cycle later. When blocked, it leaves the whole status byte unchanged.
- R8: After reset, the latch is 0, the fence code and lock bit hold their parameter values, and the captured pin reads high (unlocked).
- R9: With fence code 11, the lock bit 1 and the captured pin low, both `mem_wr_ok` and `sr_wr_ok` stay 0 under any sequence of command strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_fall | input | 1 | One-cycle strobe at chip-select falling edge; captures the pin |
| wp_n_pin | input | 1 | Hardware write-protect pin, low means protect |
| cmd_wren | input | 1 | Set-write-enable command strobe |
| cmd_wrdi | input | 1 | Clear-write-enable command strobe |
| cmd_wrsr | input | 1 | Write-status command strobe |
| wrsr_data | input | 8 | Data byte for the status write |
| mem_addr | input | ADDR_W | Address of the memory byte being written |
| status_byte | output | 8 | Status byte for reads |
| mem_wr_ok | output | 1 | Memory write allowed at `mem_addr` |
| sr_wr_ok | output | 1 | Status write allowed |

## Verification
The assertions assume that the command decoder raises at most one command strobe per cycle, because a simultaneous set and clear of the latch has no defined order. They also assume that the strobes last a single cycle. The bench drives each strobe for exactly one clock on the falling edge and never overlaps two commands. It holds `wp_n_pin` steady around each `cs_fall` pulse and moves it between pulses only to show that the captured value does not follow it.

// File: rtl/srwp_pkg.sv
package srwp_pkg;
    typedef enum logic {
        WEL_CLEAR = 1'b0,
        WEL_SET   = 1'b1
    } wel_state_t;

    typedef enum logic [1:0] {
        FENCE_NONE    = 2'b00,
        FENCE_QUARTER = 2'b01,
        FENCE_HALF    = 2'b10,
        FENCE_ALL     = 2'b11
    } fence_code_t;

    localparam int SB_WEL_BIT   = 1;
    localparam int SB_FENCE_LO  = 2;
    localparam int SB_FENCE_HI  = 3;
    localparam int SB_LOCK_BIT  = 7;
    localparam int SB_ONE_BIT   = 6;
endpackage

// File: rtl/srwp_wel_fsm.sv
module srwp_wel_fsm
    import srwp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wren,
    input  logic cmd_wrdi,
    output logic wel
);
    wel_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WEL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WEL_CLEAR: if (cmd_wren) state_d = WEL_SET;   // arm
            WEL_SET:   if (cmd_wrdi) state_d = WEL_CLEAR; // disarm
            default:   state_d = WEL_CLEAR;
        endcase
    end

    always_comb begin
        wel = (state_q == WEL_SET);
    end

    // R2
    wel_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cmd_wren));
    // R2
    wel_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> $past(cmd_wrdi));
endmodule

// File: rtl/srwp_fence.sv
module srwp_fence
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fence,
    input  logic [ADDR_W-1:0] addr,
    output logic              guarded
);
    localparam int TOP = ADDR_W - 1;
    localparam int NXT = ADDR_W - 2;

    fence_code_t code;

    always_comb begin
        code = fence_code_t'(fence);
        unique case (code)
            FENCE_NONE:    guarded = 1'b0;
            FENCE_QUARTER: guarded = addr[TOP] & addr[NXT];
            FENCE_HALF:    guarded = addr[TOP];
            FENCE_ALL:     guarded = 1'b1;
            default:       guarded = 1'b1;
        endcase
    end

    // R3
    fence_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fence == 2'b11) |-> guarded);
    // R3
    fence_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fence == 2'b00) |-> !guarded);
endmodule

// File: rtl/srwp_nv_regs.sv
module srwp_nv_regs
    import srwp_pkg::*;
#(
    parameter logic [1:0] FENCE_INIT = 2'b00,
    parameter logic       LOCK_INIT  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wel,
    input  logic       cs_fall,
    input  logic       wp_n_pin,
    input  logic       cmd_wrsr,
    input  logic [7:0] wrsr_data,
    output logic [1:0] fence,
    output logic       lock,
    output logic       pin_cap,
    output logic       sr_wr_ok
);
    logic [1:0] fence_q;
    logic       lock_q;
    logic       pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pin_q <= 1'b1;
        else if (cs_fall) pin_q <= wp_n_pin;
    end

    always_comb begin
        sr_wr_ok = wel & ~(lock_q & ~pin_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fence_q <= FENCE_INIT;
            lock_q  <= LOCK_INIT;
        end else if (cmd_wrsr && sr_wr_ok) begin
            fence_q <= wrsr_data[SB_FENCE_HI:SB_FENCE_LO];
            lock_q  <= wrsr_data[SB_LOCK_BIT];
        end
    end

    assign fence   = fence_q;
    assign lock    = lock_q;
    assign pin_cap = pin_q;

    // R6
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall |=> $stable(pin_q));
    // R7
    blocked_wrsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && !sr_wr_ok) |=> ($stable(fence_q) && $stable(lock_q)));
    // R7
    no_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wrsr |=> ($stable(fence_q) && $stable(lock_q)));
endmodule

// File: rtl/srwp_status_top.sv
module srwp_status_top
    import srwp_pkg::*;
#(
    parameter int         ADDR_W     = 18,
    parameter logic [1:0] FENCE_INIT = 2'b00,
    parameter logic       LOCK_INIT  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              wp_n_pin,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        status_byte,
    output logic              mem_wr_ok,
    output logic              sr_wr_ok
);
    logic       wel;
    logic [1:0] fence;
    logic       lock;
    logic       pin_cap;
    logic       guarded;

    srwp_wel_fsm u_wel (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wren (cmd_wren),
        .cmd_wrdi (cmd_wrdi),
        .wel      (wel)
    );

    srwp_nv_regs #(
        .FENCE_INIT (FENCE_INIT),
        .LOCK_INIT  (LOCK_INIT)
    ) u_nv (
        .clk       (clk),
        .rst_n     (rst_n),
        .wel       (wel),
        .cs_fall   (cs_fall),
        .wp_n_pin  (wp_n_pin),
        .cmd_wrsr  (cmd_wrsr),
        .wrsr_data (wrsr_data),
        .fence     (fence),
        .lock      (lock),
        .pin_cap   (pin_cap),
        .sr_wr_ok  (sr_wr_ok)
    );

    srwp_fence #(
        .ADDR_W (ADDR_W)
    ) u_fence (
        .clk     (clk),
        .rst_n   (rst_n),
        .fence   (fence),
        .addr    (mem_addr),
        .guarded (guarded)
    );

    always_comb begin
        status_byte              = 8'h00;
        status_byte[SB_ONE_BIT]  = 1'b1;
        status_byte[SB_LOCK_BIT] = lock;
        status_byte[SB_FENCE_HI:SB_FENCE_LO] = fence;
        status_byte[SB_WEL_BIT]  = wel;
        mem_wr_ok                = wel & ~guarded;
    end

    // R4
    mem_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_ok |-> status_byte[SB_WEL_BIT]);
    // R9
    lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fence == 2'b11 && lock && !pin_cap) |-> (!mem_wr_ok && !sr_wr_ok));
    // R2
    wrsr_keeps_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && !cmd_wren && !cmd_wrdi) |=> $stable(wel));
endmodule

// File: tb/srwp_status_top_tb_top.sv
`timescale 1ns/1ps
module srwp_status_top_tb_top;
    localparam int ADDR_W = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_fall = 1'b0, wp_n_pin = 1'b1;
    logic cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0;
    logic [7:0] wrsr_data = 8'h00;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic [7:0] status_byte;
    logic mem_wr_ok, sr_wr_ok;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    logic       m_wel = 1'b0, m_lock = 1'b0, m_pin = 1'b1;
    logic [1:0] m_fence = 2'b00;

    always #2 clk = ~clk;

    srwp_status_top #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .wp_n_pin(wp_n_pin),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .wrsr_data(wrsr_data), .mem_addr(mem_addr),
        .status_byte(status_byte), .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok)
    );

    function automatic logic exp_guard(input logic [1:0] f, input logic [ADDR_W-1:0] a);
        case (f)
            2'b00:   return 1'b0;
            2'b01:   return a >= 18'h30000;
            2'b10:   return a >= 18'h20000;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        logic [7:0] es;
        es = {m_lock, 1'b1, 2'b00, m_fence, m_wel, 1'b0};
        chk({req, " status"}, 32'(status_byte), 32'(es));
        chk({req, " sr_ok"}, 32'(sr_wr_ok), 32'(m_wel & ~(m_lock & ~m_pin)));
        chk({req, " mem_ok"}, 32'(mem_wr_ok), 32'(m_wel & ~exp_guard(m_fence, mem_addr)));
    endtask

    task automatic wren();
        @(negedge clk) cmd_wren = 1'b1;
        @(negedge clk) cmd_wren = 1'b0;
        m_wel = 1'b1;
    endtask

    task automatic wrdi();
        @(negedge clk) cmd_wrdi = 1'b1;
        @(negedge clk) cmd_wrdi = 1'b0;
        m_wel = 1'b0;
    endtask

    task automatic wrsr(input logic [7:0] d);
        @(negedge clk) begin cmd_wrsr = 1'b1; wrsr_data = d; end
        @(negedge clk) cmd_wrsr = 1'b0;
        if (m_wel && !(m_lock && !m_pin)) begin
            m_fence = d[3:2];
            m_lock  = d[7];
        end
    endtask

    task automatic csf(input logic pin);
        @(negedge clk) begin wp_n_pin = pin; cs_fall = 1'b1; end
        @(negedge clk) cs_fall = 1'b0;
        m_pin = pin;
    endtask

    task automatic t_reset();
        check_state("R8 reset");
        chk("R8 reset byte", 32'(status_byte), 32'h40);
    endtask

    task automatic t_wel();
        wren();  check_state("R2 arm");
        wrsr(8'h00); check_state("R2 wrsr bit1=0 keeps latch");
        wrdi();  check_state("R2 disarm");
        wrsr(8'hFF); check_state("R7 blocked without latch");
        wren(); wrsr(8'hB1);  check_state("R1 fixed bits after 8'hB1");
        wrsr(8'h00); check_state("R7 clear fields");
    endtask

    task automatic t_ranges();
        logic [ADDR_W-1:0] probes [6] = '{18'h00000, 18'h1FFFF, 18'h20000,
                                          18'h2FFFF, 18'h30000, 18'h3FFFF};
        for (int c = 0; c < 4; c++) begin
            wrsr(8'(c << 2));
            for (int i = 0; i < 6; i++) begin
                mem_addr = probes[i];
                #1 check_state("R3 fence decode");
            end
        end
        wrdi(); mem_addr = 18'h00000;
        #1 check_state("R4 no latch blocks mem");
    endtask

    task automatic t_pin();
        wren(); wrsr(8'h00);
        csf(1'b0); check_state("R5 pin ignored when unlocked");
        wrsr(8'h84); check_state("R5 lock set with pin low");
        wrsr(8'h00); check_state("R7 locked write blocked");
        @(negedge clk) wp_n_pin = 1'b1;
        @(negedge clk) check_state("R6 pin change without cs_fall");
        csf(1'b1); check_state("R6 pin captured high");
        wrsr(8'h80); check_state("R5 unlocked by pin");
    endtask

    task automatic t_lockout();
        wrsr(8'h8C); csf(1'b0);
        mem_addr = 18'h00010;
        wren(); check_state("R9 after wren");
        wrsr(8'h00); check_state("R9 wrsr rejected");
        wrdi(); wren(); check_state("R9 rearm still blocked");
        csf(1'b1); wrsr(8'h00); check_state("R9 released by pin high");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wel();
        t_ranges();
        t_pin();
        t_lockout();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule